// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is a register-driven master for the two-wire PHY management bus. Software writes one packed 32-bit maintenance word. The word holds the start code, the operation, the PHY address, the register address, the turnaround code and a 16-bit data field. When the management port is enabled, that single write launches a complete Clause-22 frame on MDC/MDIO. The frame starts with a run of preamble ones, followed by the 32 bits of the word, most significant bit first.

For a read, the engine stops driving the line at the second turnaround bit. It then shifts the 16 bits returned by the PHY into the low half of the same maintenance word, so software gets the result by reading that word back. A status word carries an idle bit at position 2. Software polls this bit before and after each operation. MDC is the bus clock divided by 48 or 64, chosen by a select input, and it is held low whenever no frame is in flight.

Top module: `mdio_frame_engine`

## Requirements
- R1: A launched frame shifts out 32 ones and then maintenance word bits 31 down to 0. The word packs start code 01 at 31:30, operation at 29:28, PHY address at 27:23, register address at 22:18, turnaround 10 at 17:16 and data at 15:0. The frame uses 64 MDC periods.
- R2: A read is operation code 10 (bit 29 set, bit 28 clear). For a read, the MDIO output enable is low for frame bits 47 through 63 (second turnaround bit to the last data bit), and MDIO out is held at 1 while released. Every other operation code drives all 64 bits.
- R3: During a read, MDIO in is sampled on each MDC rising edge of the 16 data bits and shifted into maintenance word bits 15:0. Bits 31:16 are kept, and the result is visible on the read-back port once idle returns.
- R4: Status bit 2 is high whenever no frame is running. It goes low in the cycle after an accepted launch and stays low for exactly 64 × divisor bus cycles.
- R5: With divider select 0 the MDC period is 48 bus cycles, and with 1 it is 64. The first MDC rising edge follows the launch by half a period.
- R6: While a frame runs, MDIO out changes only in a cycle where MDC falls.
- R7: While the management enable is low, a maintenance write updates the stored word but starts no frame, and MDC stays low. Clearing the enable during a frame ends it in the next cycle, with idle high, MDC low and the output enable low.
- R8: A maintenance write that arrives while a frame is running is ignored. Neither the stored word nor the frame on the wire changes.
- R9: After reset the maintenance word reads 0, the idle bit is 1, MDC is 0, the output enable is 0 and MDIO out is 1.
- R10: A non-read frame leaves the maintenance word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| mntWrEn | input | 1 | Write strobe for the maintenance word |
| mntWrData | input | 32 | Maintenance word to write |
| mntRdData | output | 32 | Current maintenance word (read data lands in 15:0) |
| statusRd | output | 32 | Status word; bit 2 is the idle flag, other bits 0 |
| mdioEnable | input | 1 | Management port enable |
| divSel | input | 1 | MDC divider select: 0 gives 48, 1 gives 64 |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output value |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO input from the PHY |

## Verification
The bench models a PHY that counts MDC edges on its own and answers reads bit by bit. It records every bit the engine drives and the output-enable state at each rising MDC edge.

The bench runs read frames with responses at all-ones, all-zeros and alternating values, on both dividers:
- A release one bit late or early would show up as a driven bit 47 or a floating bit 46.
- A shift on the wrong MDC edge would corrupt the captured word by one position.

The bench also measures the busy window and the first MDC rise:
- An off-by-one in the divider or in the bit count shows up as a window that is too long or too short.

Two directed cases target state that should not change:
- A write in mid-frame, which a design without the busy gate would let overwrite the word.
- Clearing the enable mid-frame, which a design would get wrong by leaving MDC high or the line driven.

// File: rtl/mdio_fe_pkg.sv
package mdio_fe_pkg;
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             load;
    logic             rise;
    logic             fall;
    logic             abort;
    logic             busy;
    logic [IDX_W-1:0] bitIdx;
  } mdio_ctl_s;
endpackage

// File: rtl/mdio_fe_ctrl.sv
module mdio_fe_ctrl
  import mdio_fe_pkg::*;
#(
  parameter int DIV_A         = 48,
  parameter int DIV_B         = 64,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      mntWrEn,
  input  logic      mdioEnable,
  input  logic      divSel,
  output mdio_ctl_s ctl
);
  localparam int FRAME_BITS = PREAMBLE_BITS + 32;
  localparam int DIV_MAX    = (DIV_A > DIV_B) ? DIV_A : DIV_B;
  localparam int CW         = $clog2(DIV_MAX);
  localparam logic [CW-1:0] A_LAST = CW'(DIV_A - 1);
  localparam logic [CW-1:0] B_LAST = CW'(DIV_B - 1);
  localparam logic [CW-1:0] A_RISE = CW'(DIV_A / 2 - 1);
  localparam logic [CW-1:0] B_RISE = CW'(DIV_B / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e              state;
  logic [CW-1:0]    cnt;
  logic             selQ;
  logic [IDX_W-1:0] bitIdx;
  logic [CW-1:0]    divLast;
  logic [CW-1:0]    riseAt;
  logic             running;
  logic             startReq;

  // Divider choice is frozen at launch so a mid-frame change cannot skew a period.
  assign divLast  = selQ ? B_LAST : A_LAST;
  assign riseAt   = selQ ? B_RISE : A_RISE;
  assign running  = (state == ST_RUN);
  assign startReq = (state == ST_IDLE) && mntWrEn && mdioEnable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      selQ   <= 1'b0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            state  <= ST_RUN;
            cnt    <= '0;
            bitIdx <= '0;
            selQ   <= divSel;
          end
        end
        ST_RUN: begin
          if (!mdioEnable) begin
            state <= ST_IDLE;
          end else if (cnt == divLast) begin
            cnt <= '0;
            if (bitIdx == LAST_BIT) state <= ST_IDLE;
            else                    bitIdx <= bitIdx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load   = startReq;
    ctl.rise   = running && mdioEnable && (cnt == riseAt);
    ctl.fall   = running && mdioEnable && (cnt == divLast);
    ctl.abort  = running && !mdioEnable;
    ctl.busy   = running;
    ctl.bitIdx = bitIdx;
  end
endmodule

// File: rtl/mdio_fe_datapath.sv
module mdio_fe_datapath
  import mdio_fe_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdio_ctl_s   ctl,
  input  logic        mntWrEn,
  input  logic [31:0] mntWrData,
  input  logic        mdioIn,
  output logic [31:0] word,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe
);
  localparam int FRAME_BITS = PREAMBLE_BITS + 32;
  localparam logic [IDX_W-1:0] TA_SECOND  = IDX_W'(PREAMBLE_BITS + 15);
  localparam logic [IDX_W-1:0] DATA_FIRST = IDX_W'(PREAMBLE_BITS + 16);
  localparam logic [IDX_W-1:0] PRE_END    = IDX_W'(PREAMBLE_BITS);
  localparam logic [IDX_W-1:0] TOP_IDX    = IDX_W'(FRAME_BITS - 1);

  logic             isRead;
  logic             released;
  logic [IDX_W-1:0] fieldPos;
  logic             txBit;

  assign isRead   = (word[29:28] == 2'b10);
  assign released = isRead && (ctl.bitIdx >= TA_SECOND);
  // Past the preamble, frame position maps onto word bit 31 down to 0.
  assign fieldPos = TOP_IDX - ctl.bitIdx;
  assign txBit    = (ctl.bitIdx < PRE_END) ? 1'b1 : word[fieldPos[4:0]];
  assign mdioOe   = ctl.busy && !released;
  assign mdioOut  = mdioOe ? txBit : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word <= '0;
    end else if (mntWrEn && !ctl.busy) begin
      word <= mntWrData;
    end else if (ctl.rise && isRead && (ctl.bitIdx >= DATA_FIRST)) begin
      word[15:0] <= {word[14:0], mdioIn};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                mdc <= 1'b0;
    else if (ctl.abort || ctl.fall || ctl.load) mdc <= 1'b0;
    else if (ctl.rise)                        mdc <= 1'b1;
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_fe_pkg::*;
#(
  parameter int DIV_A         = 48,
  parameter int DIV_B         = 64,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mntWrEn,
  input  logic [31:0] mntWrData,
  output logic [31:0] mntRdData,
  output logic [31:0] statusRd,
  input  logic        mdioEnable,
  input  logic        divSel,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdio_ctl_s ctl;

  mdio_fe_ctrl #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .PREAMBLE_BITS(PREAMBLE_BITS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .mntWrEn(mntWrEn),
    .mdioEnable(mdioEnable), .divSel(divSel), .ctl(ctl)
  );

  mdio_fe_datapath #(
    .PREAMBLE_BITS(PREAMBLE_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mntWrEn(mntWrEn),
    .mntWrData(mntWrData), .mdioIn(mdioIn), .word(mntRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  assign statusRd = {29'd0, !ctl.busy, 2'b00};
endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mntWrEn,
  input logic        mdioEnable,
  input logic        idleBit,
  input logic [15:0] hdrBits,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  // R7: no clock and no drive while idle
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    idleBit |-> (!mdc && !mdioOe));

  // R6: line changes only with a falling MDC
  p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!idleBit && $past(!idleBit) && !$stable(mdioOut)) |-> $fell(mdc));

  // R8: a busy-time write leaves the header half untouched
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!idleBit && mntWrEn) |=> (hdrBits == $past(hdrBits)));

  // R4: an accepted launch clears idle next cycle
  p_launch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (idleBit && mntWrEn && mdioEnable) |=> !idleBit);

  // R2: release happens only for read frames
  p_oe_read_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!idleBit && !mdioOe) |-> (hdrBits[13:12] == 2'b10));

  // R2: a released line idles high
  p_released_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !mdioOe |-> mdioOut);
endmodule

bind mdio_frame_engine mdio_frame_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .mntWrEn(mntWrEn), .mdioEnable(mdioEnable),
  .idleBit(statusRd[2]), .hdrBits(mntRdData[31:16]), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_frame_engine_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mntWrEn = 1'b0;
  logic [31:0] mntWrData = '0;
  logic [31:0] mntRdData;
  logic [31:0] statusRd;
  logic        mdioEnable = 1'b1;
  logic        divSel = 1'b0;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] respReg = '0;
  logic [63:0] capOut = '0;
  logic [63:0] capOe = '0;

  always #4 clk = ~clk;

  mdio_frame_engine dut_i (
    .clk(clk), .rstN(rstN), .mntWrEn(mntWrEn), .mntWrData(mntWrData),
    .mntRdData(mntRdData), .statusRd(statusRd), .mdioEnable(mdioEnable),
    .divSel(divSel), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  // {divSel, isRead, phy[4:0], reg[4:0], data[15:0], resp[15:0]}
  localparam int NV = 6;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0, 1'b0, 5'h01, 5'h00, 16'h1234, 16'h0000},
    {1'b1, 1'b1, 5'h1F, 5'h01, 16'h0000, 16'hA5C3},
    {1'b0, 1'b1, 5'h00, 5'h1F, 16'hFFFF, 16'h8001},
    {1'b1, 1'b0, 5'h15, 5'h0A, 16'hFFFF, 16'h0000},
    {1'b0, 1'b1, 5'h0A, 5'h15, 16'h0000, 16'h0000},
    {1'b1, 1'b1, 5'h07, 5'h02, 16'h0000, 16'hFFFF}
  };

  // PHY model and line monitor, counting MDC edges on its own
  initial begin
    int fallCnt;
    int riseCnt;
    logic lastMdc;
    fallCnt = 0; riseCnt = 0; lastMdc = 1'b0; mdioIn = 1'b0;
    forever begin
      @(mdc or statusRd);
      if (statusRd[2]) begin
        fallCnt = 0; riseCnt = 0; lastMdc = 1'b0; mdioIn = 1'b0;
      end else begin
        if (mdc && !lastMdc) begin
          if (riseCnt < 64) begin
            capOut[63-riseCnt] = mdioOut;
            capOe[63-riseCnt]  = mdioOe;
          end
          riseCnt++;
        end else if (!mdc && lastMdc) begin
          fallCnt++;
          if (fallCnt >= 48 && fallCnt <= 63) mdioIn = respReg[63-fallCnt];
        end
        lastMdc = mdc;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkWord(input logic rd, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  task automatic runFrame(input logic [31:0] w, input logic [15:0] resp, input logic sel,
                          input bit intrude, output int k, output int firstRise);
    respReg = resp;
    divSel = sel;
    mntWrData = w;
    mntWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mntWrEn = 1'b0;
    k = 0;
    firstRise = -1;
    while (!statusRd[2] && k < 10000) begin
      if (mdc && firstRise < 0) firstRise = k;
      if (intrude && k == 300) begin
        mntWrData = ~w;
        mntWrEn = 1'b1;
      end else begin
        mntWrEn = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    mntWrEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    int fr;
    int div;
    logic [31:0] w;
    logic [63:0] expOut;
    logic [63:0] expOe;
    bit saw;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(mntRdData == 32'h0, "R9 word", 64'(mntRdData), 64'h0);
    chk(statusRd == 32'h4, "R9 status", 64'(statusRd), 64'h4);
    chk({mdc, mdioOe, mdioOut} == 3'b001, "R9 pins", 64'({mdc, mdioOe, mdioOut}), 64'h1);

    for (int i = 0; i < NV; i++) begin
      logic vSel, vRd;
      logic [15:0] vResp;
      vSel  = VEC[i][43];
      vRd   = VEC[i][42];
      vResp = VEC[i][15:0];
      w = mkWord(vRd, VEC[i][41:37], VEC[i][36:32], VEC[i][31:16]);
      div = vSel ? 64 : 48;
      runFrame(w, vResp, vSel, 1'b0, k, fr);
      expOut = {32'hFFFF_FFFF, w};
      expOe  = '1;
      if (vRd) begin
        expOut = expOut | 64'h1FFFF;
        expOe  = ~64'h1FFFF;
      end
      chk(capOut == expOut, "R1 frame bits", capOut, expOut);
      chk(capOe == expOe, "R2 output enable", capOe, expOe);
      chk(k == 64 * div, "R4 busy window", 64'(k), 64'(64 * div));
      chk(fr == div / 2, "R5 first MDC rise", 64'(fr), 64'(div / 2));
      if (vRd)
        chk(mntRdData == {w[31:16], vResp}, "R3 read capture", 64'(mntRdData), 64'({w[31:16], vResp}));
      else
        chk(mntRdData == w, "R10 write word kept", 64'(mntRdData), 64'(w));
    end

    // R8: write in mid-frame is ignored
    w = mkWord(1'b0, 5'h03, 5'h04, 16'hBEEF);
    runFrame(w, 16'h0, 1'b0, 1'b1, k, fr);
    chk(capOut == {32'hFFFF_FFFF, w}, "R8 frame unchanged", capOut, {32'hFFFF_FFFF, w});
    chk(mntRdData == w, "R8 word unchanged", 64'(mntRdData), 64'(w));
    chk(k == 64 * 48, "R8 busy window", 64'(k), 64'(64 * 48));

    // R7: clearing enable mid-frame aborts
    w = mkWord(1'b1, 5'h02, 5'h05, 16'h0);
    respReg = 16'h0;
    divSel = 1'b1;
    mntWrData = w;
    mntWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mntWrEn = 1'b0;
    repeat (1000) @(negedge clk);
    mdioEnable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk({statusRd[2], mdc, mdioOe} == 3'b100, "R7 abort", 64'({statusRd[2], mdc, mdioOe}), 64'h4);

    // R7: write while disabled stores word and starts nothing
    w = mkWord(1'b0, 5'h11, 5'h12, 16'h5A5A);
    mntWrData = w;
    mntWrEn = 1'b1;
    @(negedge clk);
    mntWrEn = 1'b0;
    saw = 0;
    for (int j = 0; j < 200; j++) begin
      if (!statusRd[2] || mdc || mdioOe) saw = 1;
      @(negedge clk);
    end
    chk(!saw, "R7 no frame while disabled", 64'(saw), 64'h0);
    chk(mntRdData == w, "R7 word stored", 64'(mntRdData), 64'(w));
    mdioEnable = 1'b1;
    repeat (5) @(negedge clk);
    chk(statusRd[2] == 1'b1, "R7 no late launch", 64'(statusRd[2]), 64'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule